// File: doc/BRIEF.md
# Multi-Register Load Sequencer

This block turns one multi-register load into a chain of single memory reads and register-file writes. A request gives a starting byte address, a first register index, a transfer mode and an endian flag. The block then drives a memory read port with one request at a time. It formats each returned datum and writes it to the register file through a single write port.

There are two modes. In word-fill mode the block reads 32-bit words at a 4-byte stride. It writes each word, zero-extended, to consecutive registers from the first index up to the last register of the file. In pair mode the block reads two doublewords, at the address and at the address plus 8, into an even/odd register pair. In big-endian order each doubleword goes unchanged into the register of matching rank. In little-endian order the two halves swap registers and each is byte-reversed. The block does not compute addresses, handle faults or cache data.

Top module: `mreg_load_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy, done, err, mem_req and rf_we are all 0.
- R2: In word-fill mode (mode=0) the block issues word reads (mem_dw=0) at start_addr, start_addr+4, ... and writes registers start_idx, start_idx+1, ... 31 in that order, one write per read.
- R3: In word-fill mode the write data is the low 32 bits of the read response with bits 63:32 forced to zero, whatever the response carries there.
- R4: In word-fill mode, a start index of 31 performs exactly one read and one register write.
- R5: In pair mode (mode=1) with big_endian=1, the block reads doublewords (mem_dw=1) at start_addr and then start_addr+8. The first response is written unchanged to register start_idx and the second to start_idx+1.
- R6: In pair mode with big_endian=0, the reads are the same as in R5. The first response is written byte-reversed (byte 0 swapped with byte 7, and so on) to register start_idx+1. The second response is written byte-reversed to register start_idx.
- R7: In pair mode, an odd start_idx makes the block finish with done=1 and err=1, with no memory request and no register write.
- R8: At most one memory read is outstanding. A new mem_req appears only after the response to the previous one has been written to the register file.
- R9: done is a single-cycle pulse in the cycle after the final register write (or after the rejected start of R7). busy is 1 from the cycle after an accepted start up to and including the done cycle.
- R10: start is ignored while busy is 1. The running operation's reads, writes and err result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| mode | input | 1 | 0 = word-fill, 1 = register-pair doubleword load |
| big_endian | input | 1 | 1 = big-endian pair ordering, 0 = little-endian |
| start_addr | input | ADDR_W | Byte address of the first read |
| start_idx | input | IDX_W | First destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Valid with done: pair mode rejected for odd index |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_dw | output | 1 | Read size: 0 = 4 bytes, 1 = 8 bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | XLEN | Read data (word reads use bits 31:0) |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | IDX_W | Register write index |
| rf_data | output | XLEN | Register write data |

## Verification
Word-fill runs begin near the top of the file, at register 31 alone, and at register 0 across the whole file. These runs separate an off-by-one end condition from a wrong stride or wrong index order. The read responses carry a nonzero upper half, so a missing zero-extension shows up. Pair loads use both endian settings with distinct data in each doubleword, which tells register swap apart from byte reversal. An odd-index pair request and a start pulse during a run show whether rejected or ignored requests leave any trace at the write port.

// File: rtl/mreg_pkg.sv
// Shared types for the multi-register load sequencer.
// Assumes: nothing beyond the standard.
package mreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/mreg_byterev.sv
// Reverses the byte order of a data word.
// Assumes: WIDTH is a multiple of 8.
module mreg_byterev #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NBYTES = WIDTH / 8;

    // Mirror byte lane i onto lane NBYTES-1-i.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[WIDTH-8-8*i +: 8];
    end
endmodule

// File: rtl/mreg_fmt.sv
// Builds the register write index and data from the captured response.
// Assumes: base_idx is even in pair mode (the controller guarantees it).
module mreg_fmt #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic             quad,
    input  logic             be,
    input  logic             half,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [XLEN-1:0]  raw,
    output logic [IDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]  wr_data
);
    localparam int WORD_W = XLEN / 2;

    logic [XLEN-1:0] swapped;

    mreg_byterev #(.WIDTH(XLEN)) u_rev (
        .din  (raw),
        .dout (swapped)
    );

    // Select data formatting per mode and endian order.
    always_comb begin
        if (quad) begin
            wr_data = be ? raw : swapped;
            wr_idx  = {base_idx[IDX_W-1:1], (be ? half : ~half)};
        end else begin
            wr_data = {{(XLEN-WORD_W){1'b0}}, raw[WORD_W-1:0]};
            wr_idx  = base_idx;
        end
    end
endmodule

// File: rtl/mreg_fsm.sv
// Sequencing controller: accepts a start, issues one read at a time,
// captures each response and steps address and register index.
// Assumes: a response arrives for every request, one cycle wide.
module mreg_fsm
    import mreg_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int ADDR_W  = 32,
    parameter int REG_CNT = 32,
    parameter int IDX_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              quad_in,
    input  logic              be_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              rsp_valid,
    input  logic [XLEN-1:0]   rsp_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dw,
    output logic              rf_we,
    output logic              quad_q,
    output logic              be_q,
    output logic              half_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [XLEN-1:0]   data_q
);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(REG_CNT - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(XLEN / 16);
    localparam logic [ADDR_W-1:0] DW_STEP   = ADDR_W'(XLEN / 8);

    seq_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic              err_q;
    logic              last;

    // Final transfer of the current operation.
    always_comb last = quad_q ? half_q : (idx_q == LAST_IDX);

    // State, address, index and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
            quad_q <= 1'b0;
            be_q   <= 1'b0;
            half_q <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= addr_in;
                        idx_q  <= idx_in;
                        quad_q <= quad_in;
                        be_q   <= be_in;
                        half_q <= 1'b0;
                        if (quad_in && idx_in[0]) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            err_q <= 1'b0;
                            state <= ST_REQ;
                        end
                    end
                end
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        data_q <= rsp_data;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (last) begin
                        state <= ST_DONE;
                    end else begin
                        state <= ST_REQ;
                        if (quad_q) begin
                            addr_q <= addr_q + DW_STEP;
                            half_q <= 1'b1;
                        end else begin
                            addr_q <= addr_q + WORD_STEP;
                            idx_q  <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    err_q <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        err      = (state == ST_DONE) && err_q;
        mem_req  = (state == ST_REQ);
        mem_addr = addr_q;
        mem_dw   = quad_q;
        rf_we    = (state == ST_WRITE);
    end
endmodule

// File: rtl/mreg_load_seq.sv
// Top level: controller plus write formatter.
// Assumes: the register file accepts one write per cycle without stall.
module mreg_load_seq #(
    parameter int XLEN    = 64,
    parameter int ADDR_W  = 32,
    parameter int REG_CNT = 32,
    parameter int IDX_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [IDX_W-1:0]  start_idx,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dw,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [XLEN-1:0]   rf_data
);
    logic             quad_q;
    logic             be_q;
    logic             half_q;
    logic [IDX_W-1:0] idx_q;
    logic [XLEN-1:0]  data_q;

    mreg_fsm #(
        .XLEN    (XLEN),
        .ADDR_W  (ADDR_W),
        .REG_CNT (REG_CNT),
        .IDX_W   (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .quad_in   (mode),
        .be_in     (big_endian),
        .addr_in   (start_addr),
        .idx_in    (start_idx),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_dw    (mem_dw),
        .rf_we     (rf_we),
        .quad_q    (quad_q),
        .be_q      (be_q),
        .half_q    (half_q),
        .idx_q     (idx_q),
        .data_q    (data_q)
    );

    mreg_fmt #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W)
    ) u_fmt (
        .quad     (quad_q),
        .be       (be_q),
        .half     (half_q),
        .base_idx (idx_q),
        .raw      (data_q),
        .wr_idx   (rf_idx),
        .wr_data  (rf_data)
    );
endmodule

// File: rtl/mreg_load_seq_chk.sv
// Protocol checker for the sequencer, attached by bind.
// Assumes: observes top-level ports only.
module mreg_load_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            mem_req,
    input logic            mem_dw,
    input logic            rf_we,
    input logic [XLEN-1:0] rf_data
);
    logic pending;
    logic last_dw;
    logic active;

    // Track the outstanding read, its size, and any read in this operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            last_dw <= 1'b0;
            active  <= 1'b0;
        end else begin
            if (mem_req) begin
                pending <= 1'b1;
                last_dw <= mem_dw;
            end else if (rf_we) begin
                pending <= 1'b0;
            end
            if (done)         active <= 1'b0;
            else if (mem_req) active <= 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req && !rf_we)); // R1
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pending); // R8
    AST_WORD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !last_dw) |-> (rf_data[XLEN-1:XLEN/2] == '0)); // R3
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (!active && !rf_we)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> $past(rf_we)); // R9
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rf_we || done) |-> busy); // R9
endmodule

bind mreg_load_seq mreg_load_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .mem_req (mem_req),
    .mem_dw  (mem_dw),
    .rf_we   (rf_we),
    .rf_data (rf_data)
);

// File: tb/mreg_load_seq_bench.sv
// Directed bench for the multi-register load sequencer.
module mreg_load_seq_bench;
    localparam int XLEN   = 64;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic              big_endian = 1'b1;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [IDX_W-1:0]  start_idx = '0;
    logic              busy, done, err, mem_req, mem_dw, rf_we;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [XLEN-1:0]   mem_rsp_data = '0;
    logic [IDX_W-1:0]  rf_idx;
    logic [XLEN-1:0]   rf_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int lat = 1;

    // Monitor logs
    logic [IDX_W-1:0]  log_idx [0:63];
    logic [XLEN-1:0]   log_data[0:63];
    logic [ADDR_W-1:0] log_addr[0:63];
    logic              log_dw  [0:63];
    int n_wr = 0, n_req = 0, n_done = 0, n_err = 0;

    always #5 clk = ~clk;

    mreg_load_seq #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_mreg_load_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .big_endian(big_endian), .start_addr(start_addr), .start_idx(start_idx),
        .busy(busy), .done(done), .err(err), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_dw(mem_dw), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_data(rf_data)
    );

    function automatic logic [31:0] word_at(input logic [ADDR_W-1:0] a);
        return (a * 32'h9E37) ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [XLEN-1:0] dw_at(input logic [ADDR_W-1:0] a);
        return {a ^ 32'h0F1E_2D3C, a + 32'h7654_3210};
    endfunction

    function automatic logic [XLEN-1:0] brev(input logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN/8; i++) r[8*i +: 8] = d[XLEN-8-8*i +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Memory responder: one response per request, lat cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [ADDR_W-1:0] a;
                logic d;
                a = mem_addr;
                d = mem_dw;
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d ? dw_at(a) : {32'hDEAD_BEEF, word_at(a)};
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    // Port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && n_req < 64) begin
                log_addr[n_req] = mem_addr;
                log_dw[n_req]   = mem_dw;
            end
            if (mem_req) n_req++;
            if (rf_we && n_wr < 64) begin
                log_idx[n_wr]  = rf_idx;
                log_data[n_wr] = rf_data;
            end
            if (rf_we) n_wr++;
            if (done) n_done++;
            if (done && err) n_err++;
        end
    end

    task automatic clear_logs();
        n_wr = 0; n_req = 0; n_done = 0; n_err = 0;
    endtask

    // Start an operation; optionally pulse start again mid-run
    task automatic run_op(input logic m, input logic be, input logic [ADDR_W-1:0] a,
                          input logic [IDX_W-1:0] idx, input bit poke);
        @(negedge clk);
        clear_logs();
        mode = m; big_endian = be; start_addr = a; start_idx = idx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            mode = 1'b1; start_idx = 5'd7; start_addr = 32'hFFFF_0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0 && n_done == 1, "R9 done single pulse", 64'(n_done), 64'd1);
        chk(busy == 1'b0, "R9 busy cleared after done", 64'(busy), 64'd0);
    endtask

    task automatic check_words(input logic [ADDR_W-1:0] a, input int first,
                               input string req);
        int n;
        n = 32 - first;
        chk(n_wr == n && n_req == n, req, 64'(n_wr), 64'(n));
        chk(n_err == 0, {req, " no err"}, 64'(n_err), 64'd0);
        for (int i = 0; i < n && i < 64; i++) begin
            logic [ADDR_W-1:0] ea;
            ea = a + 32'(4*i);
            chk(log_addr[i] == ea && log_dw[i] == 1'b0, "R2 word read address",
                64'(log_addr[i]), 64'(ea));
            chk(log_idx[i] == 5'(first + i), "R2 register order",
                64'(log_idx[i]), 64'(first + i));
            chk(log_data[i] == {32'h0, word_at(ea)}, "R3 zero-extended word",
                log_data[i], {32'h0, word_at(ea)});
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !mem_req && !rf_we, "R1 reset outputs quiet",
            64'({busy, done, err, mem_req, rf_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we, "R1 idle after release",
            64'({busy, done, mem_req, rf_we}), 64'd0);
    endtask

    task automatic test_words_top();
        lat = 1;
        run_op(1'b0, 1'b1, 32'h0000_1000, 5'd28, 1'b0);
        check_words(32'h0000_1000, 28, "R2 fill from 28");
    endtask

    task automatic test_word_single();
        lat = 2;
        run_op(1'b0, 1'b0, 32'h0000_3FFC, 5'd31, 1'b0);
        chk(n_wr == 1 && n_req == 1, "R4 single transfer at 31", 64'(n_wr), 64'd1);
        check_words(32'h0000_3FFC, 31, "R4 index 31");
    endtask

    task automatic test_words_full();
        lat = 3;
        run_op(1'b0, 1'b1, 32'h8000_0040, 5'd0, 1'b0);
        check_words(32'h8000_0040, 0, "R2 full file");
    endtask

    task automatic test_pair(input logic be, input logic [ADDR_W-1:0] a,
                             input logic [IDX_W-1:0] idx, input string req);
        logic [XLEN-1:0] d0, d1;
        lat = 1;
        run_op(1'b1, be, a, idx, 1'b0);
        d0 = dw_at(a);
        d1 = dw_at(a + 32'd8);
        chk(n_req == 2 && n_wr == 2, {req, " two transfers"}, 64'(n_wr), 64'd2);
        chk(log_addr[0] == a && log_dw[0], {req, " first read"}, 64'(log_addr[0]), 64'(a));
        chk(log_addr[1] == a + 32'd8 && log_dw[1], {req, " second read"},
            64'(log_addr[1]), 64'(a + 32'd8));
        if (be) begin
            chk(log_idx[0] == idx && log_data[0] == d0, "R5 even gets low address",
                log_data[0], d0);
            chk(log_idx[1] == (idx | 5'd1) && log_data[1] == d1, "R5 odd gets high address",
                log_data[1], d1);
        end else begin
            chk(log_idx[0] == (idx | 5'd1) && log_data[0] == brev(d0),
                "R6 odd gets reversed low address", log_data[0], brev(d0));
            chk(log_idx[1] == idx && log_data[1] == brev(d1),
                "R6 even gets reversed high address", log_data[1], brev(d1));
        end
    endtask

    task automatic test_pair_odd();
        run_op(1'b1, 1'b1, 32'h0000_5000, 5'd7, 1'b0);
        chk(n_err == 1, "R7 odd pair sets err", 64'(n_err), 64'd1);
        chk(n_wr == 0 && n_req == 0, "R7 no reads or writes",
            64'(n_wr + n_req), 64'd0);
    endtask

    task automatic test_start_busy();
        lat = 2;
        run_op(1'b0, 1'b1, 32'h0000_2000, 5'd26, 1'b1);
        chk(n_err == 0, "R10 start while busy ignored (no err)", 64'(n_err), 64'd0);
        check_words(32'h0000_2000, 26, "R10 run unchanged");
    endtask

    initial begin
        test_reset();
        test_words_top();
        test_word_single();
        test_words_full();
        test_pair(1'b1, 32'h0000_2000, 5'd6, "R5 pair BE");
        test_pair(1'b0, 32'h0000_A100, 5'd10, "R6 pair LE");
        test_pair_odd();
        test_start_busy();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule